// File: doc/BRIEF.md
# Bus Rate Enable Generator with Timer Tick Doubling

This block takes one system clock and produces clock-enable pulses for a core bus and for two peripheral buses: a fast one and a slow one. Each enable is high for exactly one system-clock cycle per period of its derived rate. Logic that uses these pulses stays in the system clock domain and gates its registers with them. The core bus runs at a power-of-two fraction of the system clock. Each peripheral bus runs at a further fraction of 1, 2, 4 or 8 of the core bus.

A separate tick serves the timers on the slow peripheral bus. When the slow bus is not undivided, this tick runs at twice the slow-bus rate. Timers therefore keep the full core rate while the slow bus is halved. A peripheral-enable register, cleared by reset, decides which peripheral outputs pass on their bus pulses.

A parameterised system frequency is checked against the maximum rate of each bus. A flag reports any configuration that would exceed one of these maxima. New divider codes never take effect mid-period. They are sampled only in the cycle where every enable pulses together, so no enable ever gets a shortened or stretched period.

Top module: `clk_en_tree`

## Requirements
- R1: The core-bus enable `ahb_en_o` pulses once every 2^`ahb_div_i` system cycles. With code 0 it stays high continuously.
- R2: Each peripheral bus enable pulses once every 2^code core-bus periods. The 2-bit code maps 0, 1, 2, 3 to ratios 1, 2, 4, 8. With code 0 the enable equals `ahb_en_o`.
- R3: Every peripheral bus pulse and every timer tick falls in a cycle where `ahb_en_o` is also high.
- R4: The slow-bus timer tick `tim_en_o` equals the slow-bus enable when its code is 0. Otherwise it pulses at twice the slow-bus rate. With the core bus undivided and slow code 1, the tick is high every cycle.
- R5: Divider codes are sampled only in a cycle where the core, fast and slow enables are all high. The new codes govern from the next cycle on, and all periods restart from that sampling cycle.
- R6: `limit_err_o` is high when, under the active codes, SYS_HZ/2^shift (rounded down) exceeds a bus limit. The limits are AHB_MAX_HZ for the core bus, LO_MAX_HZ for the slow bus and HI_MAX_HZ for the fast bus. The shift is the total division of that bus.
- R7: The peripheral-enable register is written from `pen_wdata_i` when `pen_we_i` is high, and takes effect from the next cycle. Bit i (i < N_LO) passes slow-bus pulses to `per_lo_en_o[i]`. Bit N_LO+j passes fast-bus pulses to `per_hi_en_o[j]`.
- R8: Reset clears the peripheral-enable register, so every peripheral output is low. It also sets all active codes to 1:1, so the three bus enables are high during reset and in the first cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ahb_div_i | input | AHB_CW | Core-bus division code, ratio 2^code |
| lo_div_i | input | 2 | Slow peripheral bus code (ratio 1/2/4/8) |
| hi_div_i | input | 2 | Fast peripheral bus code (ratio 1/2/4/8) |
| pen_we_i | input | 1 | Peripheral-enable register write strobe |
| pen_wdata_i | input | N_LO+N_HI | Peripheral-enable write data |
| ahb_en_o | output | 1 | Core-bus enable pulse |
| lo_en_o | output | 1 | Slow peripheral bus enable pulse |
| hi_en_o | output | 1 | Fast peripheral bus enable pulse |
| tim_en_o | output | 1 | Slow-bus timer tick |
| per_lo_en_o | output | N_LO | Gated slow-bus enables per peripheral |
| per_hi_en_o | output | N_HI | Gated fast-bus enables per peripheral |
| limit_err_o | output | 1 | Bus rate limit violation |

## Verification
The hardest situation to reach is a code change landing inside a long period. The change must stay invisible until the next common pulse, and the next codes must then be the ones present at that pulse. The stimulus sets the slowest configurations, with periods of up to 1024 cycles. It then rewrites the codes every few cycles, so several values come and go between common pulses. The behavioural model predicts which value gets sampled and checks every enable on every cycle.

// File: rtl/clk_en_tree_pkg.sv
package clk_en_tree_pkg;
  localparam int PDIV_W = 2;
  localparam int N_TAP  = 4;
  localparam int TAP_AHB = 0;
  localparam int TAP_LO  = 1;
  localparam int TAP_HI  = 2;
  localparam int TAP_TIM = 3;

  typedef logic [PDIV_W-1:0] pdiv_t;

  // timers on the slow bus run one octave above the bus unless it is 1:1
  function automatic int tim_extra(pdiv_t c);
    return (c == '0) ? 0 : int'(c) - 1;
  endfunction
endpackage

// File: rtl/clk_en_cfg.sv
module clk_en_cfg
  import clk_en_tree_pkg::*;
#(
  parameter int AHB_CW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              apply_i,
  input  logic [AHB_CW-1:0] ahb_div_i,
  input  pdiv_t             lo_div_i,
  input  pdiv_t             hi_div_i,
  output logic [AHB_CW-1:0] ahb_q_o,
  output pdiv_t             lo_q_o,
  output pdiv_t             hi_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ahb_q_o <= '0;
      lo_q_o  <= '0;
      hi_q_o  <= '0;
    end else if (apply_i) begin
      ahb_q_o <= ahb_div_i;
      lo_q_o  <= lo_div_i;
      hi_q_o  <= hi_div_i;
    end
  end
endmodule

// File: rtl/clk_en_phase.sv
module clk_en_phase #(
  parameter int CW = 11,
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] span_i,
  output logic [CW-1:0] phase_o,
  output logic          wrap_o
);
  logic [CW-1:0] mask;

  assign mask   = (CW'(1) << span_i) - CW'(1);
  assign wrap_o = (phase_o & mask) == '0;

  // restart at 1 so the wrap cycle acts as phase 0 of the new config
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= '0;
    else         phase_o <= wrap_o ? CW'(1) : phase_o + CW'(1);
  end
endmodule

// File: rtl/clk_en_tap.sv
module clk_en_tap #(
  parameter int CW = 11,
  parameter int LW = 4
) (
  input  logic [CW-1:0] phase_i,
  input  logic [LW-1:0] shift_i,
  output logic          en_o
);
  assign en_o = (phase_i & ((CW'(1) << shift_i) - CW'(1))) == '0;
endmodule

// File: rtl/clk_en_gate.sv
module clk_en_gate #(
  parameter int N_LO = 4,
  parameter int N_HI = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [N_LO+N_HI-1:0] wdata_i,
  input  logic                 lo_en_i,
  input  logic                 hi_en_i,
  output logic [N_LO-1:0]      per_lo_o,
  output logic [N_HI-1:0]      per_hi_o
);
  logic [N_LO+N_HI-1:0] pen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pen_q <= '0;
    else if (we_i) pen_q <= wdata_i;
  end

  for (genvar i = 0; i < N_LO; i++) begin : g_lo
    assign per_lo_o[i] = lo_en_i & pen_q[i];
  end
  for (genvar j = 0; j < N_HI; j++) begin : g_hi
    assign per_hi_o[j] = hi_en_i & pen_q[N_LO+j];
  end
endmodule

// File: rtl/clk_en_tree.sv
module clk_en_tree
  import clk_en_tree_pkg::*;
#(
  parameter int          AHB_CW     = 3,
  parameter int          N_LO       = 4,
  parameter int          N_HI       = 3,
  parameter int unsigned SYS_HZ     = 72_000_000,
  parameter int unsigned AHB_MAX_HZ = 72_000_000,
  parameter int unsigned LO_MAX_HZ  = 36_000_000,
  parameter int unsigned HI_MAX_HZ  = 72_000_000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AHB_CW-1:0]    ahb_div_i,
  input  logic [1:0]           lo_div_i,
  input  logic [1:0]           hi_div_i,
  input  logic                 pen_we_i,
  input  logic [N_LO+N_HI-1:0] pen_wdata_i,
  output logic                 ahb_en_o,
  output logic                 lo_en_o,
  output logic                 hi_en_o,
  output logic                 tim_en_o,
  output logic [N_LO-1:0]      per_lo_en_o,
  output logic [N_HI-1:0]      per_hi_en_o,
  output logic                 limit_err_o
);
  localparam int MAX_LOG = (1 << AHB_CW) - 1 + (1 << PDIV_W) - 1;
  localparam int CW      = MAX_LOG + 1;
  localparam int LW      = $clog2(MAX_LOG + 1);

  logic [AHB_CW-1:0] ahb_q;
  pdiv_t             lo_q, hi_q, slow_q;
  logic [LW-1:0]     span;
  logic [LW-1:0]     sh [N_TAP];
  logic [CW-1:0]     phase;
  logic              wrap;
  logic [N_TAP-1:0]  en;

  clk_en_cfg #(.AHB_CW(AHB_CW)) u_cfg (
    .clk_i, .rst_ni, .apply_i(wrap),
    .ahb_div_i, .lo_div_i, .hi_div_i,
    .ahb_q_o(ahb_q), .lo_q_o(lo_q), .hi_q_o(hi_q)
  );

  assign slow_q       = (lo_q > hi_q) ? lo_q : hi_q;
  assign span         = LW'(ahb_q) + LW'(slow_q);
  assign sh[TAP_AHB]  = LW'(ahb_q);
  assign sh[TAP_LO]   = LW'(ahb_q) + LW'(lo_q);
  assign sh[TAP_HI]   = LW'(ahb_q) + LW'(hi_q);
  assign sh[TAP_TIM]  = LW'(ahb_q) + LW'(tim_extra(lo_q));

  clk_en_phase #(.CW(CW), .LW(LW)) u_phase (
    .clk_i, .rst_ni, .span_i(span), .phase_o(phase), .wrap_o(wrap)
  );

  for (genvar t = 0; t < N_TAP; t++) begin : g_tap
    clk_en_tap #(.CW(CW), .LW(LW)) u_tap (
      .phase_i(phase), .shift_i(sh[t]), .en_o(en[t])
    );
  end

  assign ahb_en_o = en[TAP_AHB];
  assign lo_en_o  = en[TAP_LO];
  assign hi_en_o  = en[TAP_HI];
  assign tim_en_o = en[TAP_TIM];

  clk_en_gate #(.N_LO(N_LO), .N_HI(N_HI)) u_gate (
    .clk_i, .rst_ni, .we_i(pen_we_i), .wdata_i(pen_wdata_i),
    .lo_en_i(lo_en_o), .hi_en_i(hi_en_o),
    .per_lo_o(per_lo_en_o), .per_hi_o(per_hi_en_o)
  );

  always_comb begin
    limit_err_o = ((SYS_HZ >> sh[TAP_AHB]) > AHB_MAX_HZ) ||
                  ((SYS_HZ >> sh[TAP_LO])  > LO_MAX_HZ)  ||
                  ((SYS_HZ >> sh[TAP_HI])  > HI_MAX_HZ);
  end

  assert_div1_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ahb_q == '0) |-> ahb_en_o);
  assert_lo_div1_eq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_q == '0) |-> (lo_en_o == ahb_en_o));
  assert_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_en_o || hi_en_o || tim_en_o) |-> ahb_en_o);
  assert_tim_fast_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_en_o |-> tim_en_o);
  assert_cfg_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({ahb_q, lo_q, hi_q}) |-> $past(ahb_en_o && lo_en_o && hi_en_o));
endmodule

// File: tb/clk_en_tree_test.sv
`timescale 1ns/1ps
module clk_en_tree_test;
  localparam int AHB_CW = 3;
  localparam int N_LO = 4;
  localparam int N_HI = 3;
  localparam longint SYS = 72_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AHB_CW-1:0] ahb_div = '0;
  logic [1:0] lo_div = '0, hi_div = '0;
  logic pen_we = 1'b0;
  logic [N_LO+N_HI-1:0] pen_wdata = '0;
  logic ahb_en, lo_en, hi_en, tim_en, lim;
  logic [N_LO-1:0] per_lo;
  logic [N_HI-1:0] per_hi;

  int checks = 0, errors = 0, cyc = 0;

  clk_en_tree #(.AHB_CW(AHB_CW), .N_LO(N_LO), .N_HI(N_HI)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ahb_div_i(ahb_div), .lo_div_i(lo_div),
    .hi_div_i(hi_div), .pen_we_i(pen_we), .pen_wdata_i(pen_wdata),
    .ahb_en_o(ahb_en), .lo_en_o(lo_en), .hi_en_o(hi_en), .tim_en_o(tim_en),
    .per_lo_en_o(per_lo), .per_hi_en_o(per_hi), .limit_err_o(lim)
  );

  always #2.5 clk = ~clk;

  // behavioural reference: active codes, phase since last common pulse
  int ma, ml, mh, ph;
  logic [N_LO+N_HI-1:0] mpen;

  function automatic bit fires(int k);
    return (ph % (1 << k)) == 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma = 0; ml = 0; mh = 0; ph = 0; mpen = '0;
    end else begin
      int sp;
      sp = ma + ((ml > mh) ? ml : mh);
      if (pen_we) mpen = pen_wdata;
      if (fires(sp)) begin
        ma = int'(ahb_div); ml = int'(lo_div); mh = int'(hi_div); ph = 1;
      end else ph++;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      chk("R8 per_lo in reset", per_lo, 0);
      chk("R8 per_hi in reset", per_hi, 0);
      chk("R8 ahb in reset", ahb_en, 1);
    end else begin
      bit e_ahb, e_lo, e_hi, e_tim, e_lim;
      logic [N_LO-1:0] e_pl;
      logic [N_HI-1:0] e_phi;
      e_ahb = fires(ma);
      e_lo  = fires(ma + ml);
      e_hi  = fires(ma + mh);
      e_tim = fires(ma + ((ml == 0) ? 0 : ml - 1));
      e_lim = ((SYS >> ma) > 72_000_000) || ((SYS >> (ma + ml)) > 36_000_000) ||
              ((SYS >> (ma + mh)) > 72_000_000);
      for (int i = 0; i < N_LO; i++) e_pl[i] = e_lo & mpen[i];
      for (int j = 0; j < N_HI; j++) e_phi[j] = e_hi & mpen[N_LO+j];
      chk("R1/R5 ahb_en", ahb_en, e_ahb);
      chk("R2/R5 lo_en", lo_en, e_lo);
      chk("R2/R5 hi_en", hi_en, e_hi);
      chk("R4 tim_en", tim_en, e_tim);
      chk("R6 limit", lim, e_lim);
      chk("R7 per_lo", per_lo, e_pl);
      chk("R7 per_hi", per_hi, e_phi);
      chk("R3 align", (lo_en | hi_en | tim_en) & ~ahb_en, 0);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_div(int a, int l, int h);
    ahb_div = AHB_CW'(a); lo_div = 2'(l); hi_div = 2'(h);
  endtask

  task automatic wr_pen(logic [N_LO+N_HI-1:0] v);
    pen_we = 1'b1; pen_wdata = v; step(1); pen_we = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(20);                      // R1 all 1:1
    set_div(0, 1, 0); step(40);    // R4 full-rate timer with slow bus halved
    wr_pen(7'b1010101); step(30);  // R7
    set_div(0, 0, 0); step(10);    // R6 slow bus too fast
    set_div(1, 3, 2); step(5);
    set_div(2, 2, 1); step(120);   // R5 change inside a period
    wr_pen(7'b1111111);
    set_div(3, 3, 3); step(1200);
    set_div(7, 3, 3); step(30);    // R5 long window, codes churn
    for (int k = 0; k < 60; k++) begin
      set_div(k % 8, k % 4, (k + 1) % 4);
      step(7);
    end
    set_div(7, 2, 3); step(2200);
    set_div(0, 1, 2); step(1100);
    wr_pen('0); step(40);          // R7 all gated off
    rst_n = 1'b0; step(2);         // R8 second reset
    rst_n = 1'b1; step(20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule